// File: doc/BRIEF.md
# Digital SiPM Photon Counter

This block reads out a digital silicon photomultiplier built from many single-photon microcells. On every clock it takes one binary flag per microcell and gates it with a per-cell enable mask, so that hot cells can be silenced. A pipelined adder tree then counts the surviving flags in parallel. Over an acquisition window the per-cycle counts are summed, and the window also yields a coarse timestamp for its first and its last detected photon.

A start pulse opens a window. The window then runs for a programmed number of cycles, and a local time counter that restarts with each window supplies the timestamps. When the window closes, one result record is produced. The record holds the photon total, the two timestamps and a flag that is set when the total reaches a programmed threshold, which lets an upstream event builder drop dark-count noise. The threshold, the window length and the mask are held in a small write-only register interface.

Top module: `dsipm_photon_counter`

## Requirements
- R1: After reset, `rec_valid` is low and all record outputs are zero. The registers reset to all cells enabled, a threshold of 1 and a window length of 16.
- R2: `rec_count` equals the number of enabled cells that fired, summed over every sample of the window. The per-cycle sum is formed by a parallel adder tree and never exceeds the number of cells.
- R3: `rec_count` saturates at 2^ACC_W-1 instead of wrapping.
- R4: Enable bit i lives at register address 2+i/32, bit i%32, and 1 means enabled. A disabled cell adds nothing to the count and never sets a timestamp.
- R5: `rec_first` is the sample index of the first sample in the window that holds an enabled hit. The sample taken in the start-pulse cycle has index 0.
- R6: `rec_last` is the sample index of the last sample in the window that holds an enabled hit.
- R7: When a window holds no enabled hit, `rec_first` and `rec_last` are both 16'hFFFF and `rec_above` is low.
- R8: `rec_above` is high exactly when the window holds at least one enabled hit and `rec_count` is greater than or equal to the threshold at address 0.
- R9: A window covers the start-pulse cycle plus the cycles that follow, for a total given by the length at address 1. A length of 0 acts as 1. Hits outside the window are ignored.
- R10: A start pulse that arrives while a window is open is ignored. The running window keeps its timing and its total.
- R11: `rec_valid` is a one-cycle pulse. With 64 cells it rises four clock edges after the edge that samples the window's last cycle, which is 1 + ceil(log2(cells)/2) register stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_hits | input | N_CELLS | Microcell fired flags, one per cell |
| win_start | input | 1 | Pulse that opens an acquisition window |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register address: 0 threshold, 1 window length, 2+ enable mask words |
| cfg_wdata | input | 32 | Register write data |
| rec_valid | output | 1 | Record valid pulse |
| rec_count | output | ACC_W | Photon total of the window |
| rec_first | output | 16 | First-hit sample index, or all ones |
| rec_last | output | 16 | Last-hit sample index, or all ones |
| rec_above | output | 1 | Total reached the threshold |

## Verification
The bench sets the threshold both equal to the total and one above it. A design with an off-by-one compare would show up as a wrong flag in one of those two cases. It drives hits only on masked cells. A design that applied the mask late or not at all would then report a nonzero total or real timestamps where the all-ones code belongs. It also runs a window of all-ones hits long enough to overflow the accumulator, which exposes a design that wraps. Finally it pulses start in the middle of a window, places hits on the very first and very last sample, and drives hits outside the window. A design that restarts its time counter, drops an edge sample or counts stray hits would report a wrong total or timestamp, and the record latency is checked in every window.

// File: rtl/sipm_pkg.sv
package sipm_pkg;
  localparam int TS_W       = 16;
  localparam int CFG_DW     = 32;
  localparam int ADDR_THR   = 0;
  localparam int ADDR_WIN   = 1;
  localparam int ADDR_MASK0 = 2;

  typedef struct packed {
    logic            vld;
    logic            last;
    logic [TS_W-1:0] ts;
  } tag_t;
endpackage

// File: rtl/sipm_cfg_regs.sv
module sipm_cfg_regs
  import sipm_pkg::*;
#(
  parameter int N_CELLS = 64,
  parameter int ACC_W   = 16,
  parameter int CFG_AW  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CFG_AW-1:0] addr,
  input  logic [CFG_DW-1:0] wdata,
  output logic [N_CELLS-1:0] en_mask,
  output logic [ACC_W-1:0]  thr,
  output logic [TS_W-1:0]   win_len
);
  localparam int MW = (N_CELLS + CFG_DW - 1) / CFG_DW;

  logic [MW*CFG_DW-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '1;
      thr     <= ACC_W'(1);
      win_len <= TS_W'(16);
    end else if (we) begin
      if (int'(addr) == ADDR_THR) thr <= ACC_W'(wdata);
      if (int'(addr) == ADDR_WIN) win_len <= TS_W'(wdata);
      for (int w = 0; w < MW; w++) begin
        if (int'(addr) == ADDR_MASK0 + w) mask_q[w*CFG_DW +: CFG_DW] <= wdata;
      end
    end
  end

  assign en_mask = mask_q[N_CELLS-1:0];
endmodule

// File: rtl/sipm_window_ctl.sv
module sipm_window_ctl
  import sipm_pkg::*;
#(
  parameter int N_CELLS = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               win_start,
  input  logic [N_CELLS-1:0] hits,
  input  logic [N_CELLS-1:0] en_mask,
  input  logic [TS_W-1:0]    win_len,
  output logic [N_CELLS-1:0] masked_q,
  output tag_t               tag_q,
  output logic               active_q
);
  logic [TS_W-1:0] tcnt_q, cur_t, len_m1;
  logic            accept, cur_in, cur_last;

  always_comb begin
    accept   = win_start && !active_q;
    cur_in   = accept || active_q;
    cur_t    = accept ? '0 : tcnt_q;
    len_m1   = (win_len == '0) ? '0 : win_len - 1'b1;
    cur_last = cur_in && (cur_t >= len_m1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      tcnt_q   <= '0;
      masked_q <= '0;
      tag_q    <= '0;
    end else begin
      masked_q   <= hits & en_mask;
      tag_q.vld  <= cur_in;
      tag_q.last <= cur_last;
      tag_q.ts   <= cur_t;
      if (cur_in && !cur_last) begin
        active_q <= 1'b1;
        tcnt_q   <= cur_t + 1'b1;
      end else begin
        active_q <= 1'b0;
        tcnt_q   <= '0;
      end
    end
  end
endmodule

// File: rtl/sipm_popcount_tree.sv
module sipm_popcount_tree
  import sipm_pkg::*;
#(
  parameter int N_IN  = 64,
  parameter int OUT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IN-1:0]  bits,
  input  tag_t             tag_in,
  output logic [OUT_W-1:0] sum,
  output tag_t             tag_out
);
  localparam int LEVELS = $clog2(N_IN);
  localparam int NP     = 1 << LEVELS;
  localparam int RS     = (LEVELS + 1) / 2;

  for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
    logic [OUT_W-1:0] v [NP >> l];
    if (l == 0) begin : g_leaf
      for (genvar i = 0; i < NP; i++) begin : g_bit
        if (i < N_IN) begin : g_used
          assign v[i] = {{(OUT_W-1){1'b0}}, bits[i]};
        end else begin : g_pad
          assign v[i] = '0;
        end
      end
    end else if ((l % 2 == 0) || (l == LEVELS)) begin : g_reg
      for (genvar i = 0; i < (NP >> l); i++) begin : g_node
        always_ff @(posedge clk) v[i] <= g_lvl[l-1].v[2*i] + g_lvl[l-1].v[2*i+1];
      end
    end else begin : g_comb
      for (genvar i = 0; i < (NP >> l); i++) begin : g_node
        assign v[i] = g_lvl[l-1].v[2*i] + g_lvl[l-1].v[2*i+1];
      end
    end
  end

  assign sum = g_lvl[LEVELS].v[0];

  tag_t tag_q [RS];
  for (genvar s = 0; s < RS; s++) begin : g_tag
    always_ff @(posedge clk) begin
      if (rst) tag_q[s] <= '0;
      else if (s == 0) tag_q[s] <= tag_in;
      else tag_q[s] <= tag_q[(s == 0) ? 0 : s-1];
    end
  end
  assign tag_out = tag_q[RS-1];
endmodule

// File: rtl/sipm_event_accum.sv
module sipm_event_accum
  import sipm_pkg::*;
#(
  parameter int ACC_W = 16,
  parameter int SUM_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SUM_W-1:0] sum,
  input  tag_t             tag,
  input  logic [ACC_W-1:0] thr,
  output logic             rec_valid,
  output logic [ACC_W-1:0] rec_count,
  output logic [TS_W-1:0]  rec_first,
  output logic [TS_W-1:0]  rec_last,
  output logic             rec_above
);
  logic [ACC_W-1:0] acc_q, acc_n;
  logic [ACC_W:0]   tot;
  logic [TS_W-1:0]  first_q, last_q, first_n, last_n;
  logic             seen_q, seen_n, hit;

  always_comb begin
    tot     = {1'b0, acc_q} + (ACC_W+1)'(sum);
    acc_n   = tot[ACC_W] ? '1 : tot[ACC_W-1:0];
    hit     = tag.vld && (sum != '0);
    seen_n  = seen_q || hit;
    first_n = (hit && !seen_q) ? tag.ts : first_q;
    last_n  = hit ? tag.ts : last_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      seen_q    <= 1'b0;
      first_q   <= '0;
      last_q    <= '0;
      rec_valid <= 1'b0;
      rec_count <= '0;
      rec_first <= '0;
      rec_last  <= '0;
      rec_above <= 1'b0;
    end else begin
      rec_valid <= tag.vld && tag.last;
      if (tag.vld && tag.last) begin
        rec_count <= acc_n;
        rec_first <= seen_n ? first_n : '1;
        rec_last  <= seen_n ? last_n : '1;
        rec_above <= seen_n && (acc_n >= thr);
        acc_q     <= '0;
        seen_q    <= 1'b0;
      end else if (tag.vld) begin
        acc_q   <= acc_n;
        seen_q  <= seen_n;
        first_q <= first_n;
        last_q  <= last_n;
      end
    end
  end
endmodule

// File: rtl/dsipm_photon_counter.sv
module dsipm_photon_counter
  import sipm_pkg::*;
#(
  parameter int N_CELLS = 64,
  parameter int ACC_W   = 16,
  parameter int CFG_AW  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_CELLS-1:0] cell_hits,
  input  logic               win_start,
  input  logic               cfg_we,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [31:0]        cfg_wdata,
  output logic               rec_valid,
  output logic [ACC_W-1:0]   rec_count,
  output logic [TS_W-1:0]    rec_first,
  output logic [TS_W-1:0]    rec_last,
  output logic               rec_above
);
  localparam int SUM_W = $clog2(N_CELLS) + 1;

  logic [N_CELLS-1:0] en_mask, masked;
  logic [ACC_W-1:0]   thr_w;
  logic [TS_W-1:0]    win_len;
  logic               active_w;
  tag_t               tag0, sum_tag;
  logic [SUM_W-1:0]   sum;

  sipm_cfg_regs #(.N_CELLS(N_CELLS), .ACC_W(ACC_W), .CFG_AW(CFG_AW)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .en_mask(en_mask), .thr(thr_w), .win_len(win_len)
  );

  sipm_window_ctl #(.N_CELLS(N_CELLS)) u_win (
    .clk(clk), .rst(rst), .win_start(win_start), .hits(cell_hits),
    .en_mask(en_mask), .win_len(win_len), .masked_q(masked),
    .tag_q(tag0), .active_q(active_w)
  );

  sipm_popcount_tree #(.N_IN(N_CELLS), .OUT_W(SUM_W)) u_tree (
    .clk(clk), .rst(rst), .bits(masked), .tag_in(tag0),
    .sum(sum), .tag_out(sum_tag)
  );

  sipm_event_accum #(.ACC_W(ACC_W), .SUM_W(SUM_W)) u_acc (
    .clk(clk), .rst(rst), .sum(sum), .tag(sum_tag), .thr(thr_w),
    .rec_valid(rec_valid), .rec_count(rec_count), .rec_first(rec_first),
    .rec_last(rec_last), .rec_above(rec_above)
  );
endmodule

// File: rtl/sipm_checker.sv
module sipm_checker
  import sipm_pkg::*;
#(
  parameter int N_CELLS = 64,
  parameter int ACC_W   = 16,
  parameter int SUM_W   = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             win_start,
  input logic             active,
  input tag_t             tag0,
  input tag_t             sum_tag,
  input logic [SUM_W-1:0] sum,
  input logic [ACC_W-1:0] thr,
  input logic             rec_valid,
  input logic [ACC_W-1:0] rec_count,
  input logic [TS_W-1:0]  rec_first,
  input logic [TS_W-1:0]  rec_last,
  input logic             rec_above
);
  // R2: a per-cycle tree sum cannot exceed the cell count
  p_sum_bound_r2: assert property (@(posedge clk) disable iff (rst)
    sum_tag.vld |-> (int'(sum) <= N_CELLS));

  // R7: the no-hit code appears on both tags together, never with the flag
  p_nohit_pair_r7: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && rec_first == '1) |-> (rec_last == '1 && !rec_above));

  // R7: a zero total only comes with the no-hit code (no wrap to zero)
  p_zero_count_r7: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && rec_count == '0) |-> (rec_first == '1));

  // R6: the last tag never precedes the first tag
  p_order_r6: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && rec_first != '1) |-> (rec_first <= rec_last));

  // R8: a raised flag means the total reached the threshold
  p_thresh_r8: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && rec_above) |-> (rec_count >= thr));

  // R10: a start pulse inside an open window does not restart time
  p_no_restart_r10: assert property (@(posedge clk) disable iff (rst)
    (active && win_start) |=> (tag0.vld && tag0.ts != '0));
endmodule

bind dsipm_photon_counter sipm_checker #(
  .N_CELLS(N_CELLS), .ACC_W(ACC_W), .SUM_W(SUM_W)
) u_chk (
  .clk(clk), .rst(rst), .win_start(win_start), .active(active_w),
  .tag0(tag0), .sum_tag(sum_tag), .sum(sum), .thr(thr_w),
  .rec_valid(rec_valid), .rec_count(rec_count), .rec_first(rec_first),
  .rec_last(rec_last), .rec_above(rec_above)
);

// File: tb/tb_dsipm_photon_counter.sv
module tb_dsipm_photon_counter;
  localparam int N = 64;
  localparam int NOHIT = 65535;

  typedef struct packed {
    int w; int thr; int mode; int cnt; int first; int last; int above;
  } vec_t;

  // window length, threshold, hit pattern, expected count/first/last/flag
  localparam vec_t VECS [6] = '{
    '{8,  1,   0, 0,   NOHIT, NOHIT, 0},
    '{8,  10,  1, 10,  2,     2,     1},
    '{8,  11,  1, 10,  2,     2,     0},
    '{4,  100, 2, 256, 0,     3,     1},
    '{10, 2,   3, 2,   1,     5,     1},
    '{6,  40,  4, 33,  0,     5,     0}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  cell_hits = '0;
  logic          win_start = 1'b0;
  logic          cfg_we = 1'b0;
  logic [7:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic          rec_valid, rec_above;
  logic [15:0]   rec_count, rec_first, rec_last;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dsipm_photon_counter dut (
    .clk(clk), .rst(rst), .cell_hits(cell_hits), .win_start(win_start),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .rec_valid(rec_valid), .rec_count(rec_count), .rec_first(rec_first),
    .rec_last(rec_last), .rec_above(rec_above)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] pat(input int mode, input int k, input int w);
    case (mode)
      1: return (k == 2) ? 64'h3FF : '0;
      2: return '1;
      3: return (k == 1 || k == 5) ? (64'h1 << 63) : '0;
      4: return (k == 0) ? 64'hFFFF_FFFF : ((k == w-1) ? (64'h1 << 40) : '0);
      5: return 64'h1;
      default: return '0;
    endcase
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 8'(a); cfg_wdata = 32'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // w < 0 keeps the registers untouched; restart >= 0 pulses start again
  task automatic run(input string tag, input int w, input int thr, input int mode,
                     input int restart, input bit noise, input int weff,
                     input int e_cnt, input int e_first, input int e_last, input int e_above);
    int edges = 0;
    if (w >= 0) begin
      wr(0, thr);
      wr(1, w);
    end
    if (noise) begin
      for (int i = 0; i < 3; i++) begin
        @(negedge clk); cell_hits = '1;
      end
    end
    @(negedge clk);
    win_start = 1'b1;
    cell_hits = pat(mode, 0, weff);
    while (edges < weff + 30) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      win_start = (edges == restart);
      if (edges < weff) cell_hits = pat(mode, edges, weff);
      else cell_hits = noise ? '1 : '0;
      if (rec_valid) break;
    end
    chk({tag, " R11 latency"}, edges, weff + 4);
    chk({tag, " R2 count"}, rec_count, e_cnt);
    chk({tag, " R5 first"}, rec_first, e_first);
    chk({tag, " R6 last"}, rec_last, e_last);
    chk({tag, " R8 above"}, rec_above, e_above);
    @(negedge clk);
    cell_hits = '0;
    chk({tag, " R11 pulse"}, rec_valid, 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state of the record
    chk("R1 rec_valid", rec_valid, 0);
    chk("R1 rec_count", rec_count, 0);
    chk("R1 rec_first", rec_first, 0);
    chk("R1 rec_above", rec_above, 0);
    // R1: default length 16, threshold 1, all enabled
    run("R1 defaults", -1, 0, 1, -1, 0, 16, 10, 2, 2, 1);

    foreach (VECS[i]) begin
      run($sformatf("vec%0d", i), VECS[i].w, VECS[i].thr, VECS[i].mode, -1, 0,
          VECS[i].w, VECS[i].cnt, VECS[i].first, VECS[i].last, VECS[i].above);
    end

    // R3: all cells for 1100 samples overflows 16 bits and saturates
    run("R3 saturate", 1100, 65535, 2, -1, 0, 1100, 65535, 0, 1099, 1);
    // R9: length 0 acts as 1
    run("R9 len0", 0, 64, 2, -1, 0, 1, 64, 0, 0, 1);
    // R9: hits before and after the window are ignored
    run("R9 outside", 5, 1, 0, -1, 1, 5, 0, NOHIT, NOHIT, 0);
    // R10: second start at sample 10 is ignored
    run("R10 restart", 20, 20, 5, 10, 0, 20, 20, 0, 19, 1);
    // R4: disable cells 0..31 and 63
    wr(2, 0);
    wr(3, 32'h7FFF_FFFF);
    run("R4 mask part", 6, 1, 4, -1, 0, 6, 1, 5, 5, 1);
    // R4 R7: only masked cells fire
    run("R4 R7 masked", 10, 0, 3, -1, 0, 10, 0, NOHIT, NOHIT, 0);
    wr(2, -1);
    wr(3, -1);
    run("R4 restored", 10, 2, 3, -1, 0, 10, 2, 1, 5, 1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule